// File: doc/BRIEF.md
# Clock Generator Serial Configuration Target

This block sits on a two-wire serial bus as a target device and holds the control registers of a clock generator. The bus master configures it with block-style writes. The first byte after a START carries the device address and the direction bit. A write then carries two bytes, a command and a count. The block acknowledges both and throws their contents away. Every byte after those two fills the register bank in order, starting at register 0. A read carries no command phase. It streams the registers back from register 0 upward until the master stops acknowledging.

Both bus lines are sampled on the system clock through a short synchronizer. The block pulls SDA low through a separate open-drain enable, and it changes that enable only while SCL is low. Register 0 is decoded into the clock generator's controls: a four-bit frequency-table code, a hardware/software table-select flag, a spread-spectrum enable, the spread width and an all-outputs tristate. The whole bank is also exported flat for the other registers.

Top module: `cfg_clkgen_target`

## Requirements
- R1: After reset every register bit is 0, every decoded control is 0 and the SDA pull-low output is inactive.
- R2: The first byte after START is taken MSB first. Bits 7:1 are compared with the device address (default 7'h69) and bit 0 is the direction, 1 meaning read. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: In a write, the two bytes that follow the address byte are each acknowledged, and neither is stored in any register.
- R4: Each later write byte is stored in register 0, then 1, then 2 and so on. Register i appears at bits [8i+7:8i] of the flat register output, and each stored byte is acknowledged.
- R5: A write byte beyond the last register (four registers by default) is not acknowledged and changes no register.
- R6: In a read, the target sends register 0 first and then the following registers in ascending order, MSB first, one register for each byte the master acknowledges.
- R7: Once the master does not acknowledge a read byte, the target leaves SDA released for any further clocks until the next START.
- R8: Register 0 decodes as follows. The frequency code is {bit 2, bits 6:4}. Bit 3 selects software (1) or hardware (0) table selection. Bit 1 enables spread spectrum. Bit 7 selects the wide (1) or narrow (0) spread. Bit 0 tristates all outputs.
- R9: A repeated START restarts the address phase, and the following transfer again begins at register 0.
- R10: The target changes its SDA drive only while SCL is low, so SDA stays constant throughout every SCL high period.
- R11: A non-matching address is not acknowledged, and the target then ignores all bus traffic, including a byte equal to its own address, until the next START.
- R12: A read byte addressed past the last register reads as all ones, because the target leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| freq_sel_o | output | 4 | Software frequency-table code from register 0 |
| sw_table_sel_o | output | 1 | 1 = the table is selected by the register, 0 = by pins |
| spread_en_o | output | 1 | Spread-spectrum modulation enable |
| spread_wide_o | output | 1 | 1 = wide center spread, 0 = narrow center spread |
| out_tristate_o | output | 1 | 1 = all clock outputs tristated |
| regs_o | output | NUM_REGS*8 | Whole register bank, register i at bits [8i+7:8i] |

## Verification
The hardest cases to reach are a master NACK in the middle of a read and the bytes that follow it without a STOP. So is a write that runs past the end of the bank. Neither can happen unless a bus master breaks the usual transfer shape. The bench master is bit-banged, so it can keep clocking after its own NACK, send more data bytes than there are registers, and use a repeated START to turn a write into a read. A behavioural register model checks at every quiet clock that discarded and ignored bytes never reach the bank.

// File: rtl/cfgbus_pkg.sv
// Shared types for the clock-generator configuration target.
// Assumes: byte-oriented two-wire bus, MSB first.
package cfgbus_pkg;

    localparam int BYTE_W = 8;

    // Protocol phase of the bus engine.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,   // ignoring the bus until START
        PH_ADDR   = 3'd1,   // shifting in the address byte
        PH_WRBYTE = 3'd2,   // shifting in a write byte
        PH_ACK    = 3'd3,   // target's acknowledge clock
        PH_RDBYTE = 3'd4,   // shifting out a read byte
        PH_MACK   = 3'd5    // master's acknowledge clock
    } phase_t;

endpackage

// File: rtl/cfg_line_sync.sv
// Synchronizes SCL/SDA into the system clock domain and flags edges and
// bus conditions. Assumes both lines idle high; pipeline resets to 1 so
// that no event appears out of reset.
module cfg_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_multi
            // Shift chain of capture stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Previous synchronized value, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_prev;
    assign scl_fall = ~scl_s & scl_prev;
    assign start_ev = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_ev  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/cfg_reg_bank.sv
// Bank of byte-wide control registers, written one at a time by the bus
// engine and read through an index. An index past the end reads all ones.
module cfg_reg_bank #(
    parameter int NUM_REGS = 4,
    parameter int PTR_W    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            logic [7:0] q;

            // Holds one register; loads when selected by a write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && wr_idx == PTR_W'(g)) begin
                    q <= wr_data;
                end
            end

            assign regs_flat[g*8 +: 8] = q;

            AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == PTR_W'(g)) |=> (q == $past(wr_data))); // R4
        end
    endgenerate

    // Read multiplexer; out-of-range index yields all ones.
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == PTR_W'(i)) begin
                rd_data = regs_flat[i*8 +: 8];
            end
        end
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < PTR_W'(NUM_REGS))); // R5

endmodule

// File: rtl/cfg_bus_engine.sv
// Byte-level protocol engine of the configuration target. Receives the
// address byte, acknowledges it on a match, skips two dummy bytes of a
// write and then writes the bank sequentially, or streams the bank out
// on a read. Assumes synchronized lines and single-cycle edge/event
// strobes; SDA drive changes only on an SCL falling edge.
module cfg_bus_engine
    import cfgbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 4,
    parameter int         PTR_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_pull
);

    localparam logic [PTR_W-1:0] END_PTR   = PTR_W'(NUM_REGS);
    localparam logic [1:0]       DUMMY_CNT = 2'd2;

    phase_t           phase;
    logic [2:0]       bitcnt;
    logic             byte_full;
    logic [7:0]       shreg;
    logic             rw_read;
    logic [1:0]       byte_idx;
    logic [PTR_W-1:0] ptr;
    logic             mnack;

    assign rd_idx = ptr;

    // Protocol sequencer: phases, shift register, pointer and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            byte_full <= 1'b0;
            shreg     <= '0;
            rw_read   <= 1'b0;
            byte_idx  <= '0;
            ptr       <= '0;
            mnack     <= 1'b0;
            sda_pull  <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                phase     <= PH_ADDR;
                bitcnt    <= '0;
                byte_full <= 1'b0;
                byte_idx  <= '0;
                ptr       <= '0;
                sda_pull  <= 1'b0;
            end else if (stop_ev) begin
                phase    <= PH_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR, PH_WRBYTE: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                byte_full <= 1'b1;
                            end
                        end else if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            bitcnt    <= '0;
                            if (phase == PH_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    rw_read  <= shreg[0];
                                    sda_pull <= 1'b1;
                                    phase    <= PH_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else begin
                                phase <= PH_ACK;
                                if (byte_idx != DUMMY_CNT) begin
                                    byte_idx <= byte_idx + 2'd1;
                                    sda_pull <= 1'b1;
                                end else if (ptr < END_PTR) begin
                                    wr_en    <= 1'b1;
                                    wr_idx   <= ptr;
                                    wr_data  <= shreg;
                                    ptr      <= ptr + PTR_W'(1);
                                    sda_pull <= 1'b1;
                                end else begin
                                    sda_pull <= 1'b0;
                                end
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw_read) begin
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[7];
                                phase    <= PH_RDBYTE;
                            end else begin
                                sda_pull <= 1'b0;
                                phase    <= PH_WRBYTE;
                            end
                        end
                    end
                    PH_RDBYTE: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                sda_pull <= 1'b0;
                                phase    <= PH_MACK;
                            end else begin
                                bitcnt   <= bitcnt + 3'd1;
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_pull <= ~shreg[6];
                            end
                        end
                    end
                    PH_MACK: begin
                        if (scl_rise) begin
                            mnack <= sda_s;
                            if (!sda_s && ptr < END_PTR) begin
                                ptr <= ptr + PTR_W'(1);
                            end
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (mnack) begin
                                sda_pull <= 1'b0;
                                phase    <= PH_IDLE;
                            end else begin
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[7];
                                phase    <= PH_RDBYTE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !start_ev && !stop_ev) |-> $stable(sda_pull)); // R10

    AST_NO_DUMMY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (byte_idx == DUMMY_CNT)); // R3

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (phase == PH_ADDR && ptr == '0)); // R9

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_pull); // R11

    AST_PAST_END_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RDBYTE && ptr == END_PTR) |-> !sda_pull); // R12

endmodule

// File: rtl/cfg_clkgen_target.sv
// Top of the clock-generator configuration target: line synchronizer,
// protocol engine and register bank, plus decode of register 0 into the
// clock generator's controls. Assumes an external pull-up on both lines.
module cfg_clkgen_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [3:0]            freq_sel_o,
    output logic                  sw_table_sel_o,
    output logic                  spread_en_o,
    output logic                  spread_wide_o,
    output logic                  out_tristate_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    localparam int PTR_W = $clog2(NUM_REGS + 1);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0]       rd_data;
    logic [PTR_W-1:0] rd_idx;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [7:0]       ctl0;

    cfg_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    cfg_bus_engine #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_pull (sda_pull_o)
    );

    cfg_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

    // Decode of the control register into clock generator controls.
    assign ctl0           = regs_o[7:0];
    assign freq_sel_o     = {ctl0[2], ctl0[6:4]};
    assign sw_table_sel_o = ctl0[3];
    assign spread_en_o    = ctl0[1];
    assign spread_wide_o  = ctl0[7];
    assign out_tristate_o = ctl0[0];

endmodule

// File: tb/tb_cfg_clkgen_target.sv
module tb_cfg_clkgen_target;

    localparam int         NREGS = 4;
    localparam logic [6:0] DEV   = 7'h69;
    localparam int         Q     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic [3:0] freq_sel;
    logic sw_sel, ss_en, ss_wide, tri_o;
    logic [NREGS*8-1:0] regs;

    int checks = 0;
    int errors = 0;
    int quiet = 0;
    logic scl_last = 1'b1;
    logic sda_last = 1'b1;
    logic [7:0] exp_regs [NREGS];
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    cfg_clkgen_target dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl_m),
        .sda_i          (sda_line),
        .sda_pull_o     (sda_pull),
        .freq_sel_o     (freq_sel),
        .sw_table_sel_o (sw_sel),
        .spread_en_o    (ss_en),
        .spread_wide_o  (ss_wide),
        .out_tristate_o (tri_o),
        .regs_o         (regs)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NREGS*8-1:0] exp_flat();
        logic [NREGS*8-1:0] f;
        for (int i = 0; i < NREGS; i++) f[i*8 +: 8] = exp_regs[i];
        return f;
    endfunction

    // Reference model compared on every quiet clock (bus lines settled).
    always @(negedge clk) begin
        if (scl_m !== scl_last || sda_m !== sda_last) quiet = 0;
        else if (quiet < 1000) quiet++;
        scl_last = scl_m;
        sda_last = sda_m;
        if (rst_n && quiet >= 8) begin
            chk(regs === exp_flat(), "R4 bank vs model", regs, exp_flat());
            chk(freq_sel === {exp_regs[0][2], exp_regs[0][6:4]}, "R8 freq code",
                freq_sel, {exp_regs[0][2], exp_regs[0][6:4]});
            chk({sw_sel, ss_en, ss_wide, tri_o} ===
                {exp_regs[0][3], exp_regs[0][1], exp_regs[0][7], exp_regs[0][0]},
                "R8 control bits", {sw_sel, ss_en, ss_wide, tri_o},
                {exp_regs[0][3], exp_regs[0][1], exp_regs[0][7], exp_regs[0][0]});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    // Send one byte; commit >= 0 updates the model register at bit 0's fall.
    task automatic send_byte(input logic [7:0] b, input int commit, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0;
            if (i == 0 && commit >= 0) exp_regs[commit] = b;
            tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = !sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        logic v1, v2;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            v1 = sda_line; tick(Q);
            v2 = sda_line;
            chk(v1 === v2, "R10 SDA stable while SCL high", v2, v1);
            b[i] = v1;
            scl_m = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // Write: address, two dummy bytes, then data bytes into the model.
    task automatic do_write(input logic [7:0] d [], input bit with_stop);
        bit a;
        send_byte({DEV, 1'b0}, -1, a);
        chk(a, "R2 write address ack", a, 1);
        send_byte(8'h3C, -1, a);
        chk(a, "R3 command byte ack", a, 1);
        send_byte(8'hC5, -1, a);
        chk(a, "R3 count byte ack", a, 1);
        for (int i = 0; i < d.size(); i++) begin
            send_byte(d[i], (i < NREGS) ? i : -1, a);
            if (i < NREGS) chk(a, "R4 data byte ack", a, 1);
            else           chk(!a, "R5 past-end NACK", a, 0);
        end
        if (with_stop) bus_stop();
    endtask

    task automatic do_read(input int n);
        bit a;
        logic [7:0] b;
        send_byte({DEV, 1'b1}, -1, a);
        chk(a, "R2 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            if (i < NREGS) chk(b === exp_regs[i], "R6 read data", b, exp_regs[i]);
            else           chk(b === 8'hFF, "R12 past-end reads ones", b, 8'hFF);
        end
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < NREGS; i++) exp_regs[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk(regs === '0, "R1 registers zero", regs, 0);
        chk({freq_sel, sw_sel, ss_en, ss_wide, tri_o} === '0, "R1 controls zero",
            {freq_sel, sw_sel, ss_en, ss_wide, tri_o}, 0);
        chk(sda_pull === 1'b0, "R1 SDA released", sda_pull, 0);
        tick(20);

        // R2/R3/R4: plain block write of three bytes
        bus_start();
        do_write('{8'hA5, 8'h11, 8'h22}, 1'b1);
        tick(20);
        chk(regs[7:0] === 8'hA5, "R3 command not stored", regs[7:0], 8'hA5);
        chk(freq_sel === 4'b1010, "R8 freq code for A5", freq_sel, 4'b1010);
        chk({sw_sel, ss_en, ss_wide, tri_o} === 4'b0011, "R8 bits for A5",
            {sw_sel, ss_en, ss_wide, tri_o}, 4'b0011);

        // R5: six data bytes, last two past the end
        bus_start();
        do_write('{8'h5A, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA}, 1'b1);
        tick(20);
        chk(freq_sel === 4'b0101, "R8 freq code for 5A", freq_sel, 4'b0101);
        chk({sw_sel, ss_en, ss_wide, tri_o} === 4'b1100, "R8 bits for 5A",
            {sw_sel, ss_en, ss_wide, tri_o}, 4'b1100);

        // R6/R12: read beyond the bank
        bus_start();
        do_read(6);
        bus_stop();
        tick(20);

        // R7: master NACKs then keeps clocking without STOP
        bus_start();
        do_read(2);
        for (int k = 0; k < 9; k++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            chk(sda_line === 1'b1, "R7 released after master NACK", sda_line, 1);
            tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        bus_stop();
        tick(20);

        // R11: wrong address, then own address byte must be ignored
        bus_start();
        send_byte({7'h2A, 1'b0}, -1, a);
        chk(!a, "R11 mismatch NACK", a, 0);
        send_byte({DEV, 1'b0}, -1, a);
        chk(!a, "R11 ignored until START", a, 0);
        send_byte(8'h00, -1, a);
        chk(!a, "R11 ignored data", a, 0);
        bus_stop();
        bus_start();
        send_byte({7'h68, 1'b1}, -1, a);
        chk(!a, "R11 read mismatch NACK", a, 0);
        bus_stop();
        tick(20);

        // R9: write then repeated START into a read from register 0
        bus_start();
        do_write('{8'hC3}, 1'b0);
        bus_rstart();
        send_byte({DEV, 1'b1}, -1, a);
        chk(a, "R9 address after repeated START", a, 1);
        recv_byte(1'b1, b);
        chk(b === 8'hC3, "R9 read restarts at reg 0", b, 8'hC3);
        recv_byte(1'b0, b);
        chk(b === exp_regs[1], "R9 read next reg", b, exp_regs[1]);
        bus_stop();
        tick(40);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule